// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Unit

This block serves one processor of an interrupt controller. Sources that have already been routed to this processor arrive as deliver strobes that carry a source index. The unit keeps two bit sets over the source indices: the pending set holds sources that have been delivered but not yet taken, and the in-service set holds sources that the processor has acknowledged but not yet closed. Priority, vector, activity and sense (level or edge) for every source come in on flat input buses from the source configuration logic. The unit does not hold them.

The processor takes an interrupt with an acknowledge strobe. One cycle later the unit returns either the vector of the best pending source or the spurious vector. At the same time it sends a one-cycle activity-clear pulse back to the source logic when that source must be marked inactive. An end-of-interrupt strobe closes the highest-priority in-service source. The unit holds a 4-bit task priority register and an 8-bit spurious vector register, both written from a shared write-data bus. The request line to the processor is a register that is raised on deliveries and end-of-interrupt, and re-evaluated on acknowledge.

Only one operation is taken per cycle. Acknowledge goes before end-of-interrupt, and end-of-interrupt goes before a delivery. A lower-ranked strobe in the same cycle is dropped. Writes to the two registers are independent of this order.

Top module: `cpu_iack_unit`

## Requirements
- R1: After reset `irq`, `ack_vld` and `act_clr` are 0, both sets are empty, `task_prio` is 4'hF and `spur_vec` is 8'hFF.
- R2: A `tpr_we` write keeps only bits 3:0 of `cfg_wdata` in `task_prio`. A `spv_we` write keeps only bits 7:0 of `cfg_wdata` in `spur_vec`. Neither register changes without its write strobe.
- R3: A delivery of a source that is not pending adds it to the pending set. `irq` is set one cycle later if the source's priority is strictly greater than the best pending priority before the delivery. An empty set counts as 0. The task priority plays no part in this.
- R4: A delivery of a source that is already pending is ignored.
- R5: Selection from either set takes the highest priority. On a tie the lowest source index wins.
- R6: Every `ack_req` gives `ack_vld` high for exactly the following cycle, with `ack_vec` valid. With an empty pending set `ack_vec` is the spurious vector and `act_clr` is 0.
- R7: If the selected pending source is inactive (`src_active`=0), or its priority is not strictly above `task_prio`, then `ack_vec` is the spurious vector, that source's `act_clr` bit pulses, and the source leaves the pending set without entering the in-service set.
- R8: Otherwise `ack_vec` is the source's vector, the source moves from the pending set to the in-service set, and its `act_clr` bit pulses only if it is edge-sensitive (`src_level`=0).
- R9: After an acknowledge, `irq` is 1 exactly when the remaining pending set holds a source whose priority is above both `task_prio` and the best in-service priority after the acknowledge. `irq` is therefore 0 when the pending set becomes empty.
- R10: An end-of-interrupt removes the highest-priority in-service source (R5 order). `irq` is set if the best pending priority is strictly greater than the best remaining in-service priority, and is otherwise unchanged.
- R11: `act_clr` has at most one bit set and is 0 in any cycle that does not follow an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dlv_valid | input | 1 | Deliver strobe |
| dlv_idx | input | IDX_W | Source index carried by the deliver strobe |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority, source i at bits [i*PRIO_W +: PRIO_W] |
| src_vec | input | NUM_SRC*VEC_W | Per-source vector, source i at bits [i*VEC_W +: VEC_W] |
| src_active | input | NUM_SRC | Per-source activity bit |
| src_level | input | NUM_SRC | Per-source sense, 1 = level, 0 = edge |
| tpr_we | input | 1 | Task priority write strobe |
| spv_we | input | 1 | Spurious vector write strobe |
| cfg_wdata | input | DATA_W | Shared write data for both registers |
| ack_req | input | 1 | Acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Interrupt request to the processor |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_vec | output | VEC_W | Acknowledged vector |
| act_clr | output | NUM_SRC | One-cycle activity-clear request per source |
| task_prio | output | PRIO_W | Current task priority |
| spur_vec | output | VEC_W | Current spurious vector |

## Verification
The in-line assertions check the properties that hold on every cycle. Each acknowledge gives exactly one result cycle, and an acknowledge of an empty set returns the spurious vector. An acknowledge that drains the last pending source drops the request. `act_clr` is never more than one-hot. An end-of-interrupt removes exactly one in-service source when the set is not empty. The registers hold their value without a write. Some behaviours only the bench scenarios can show, because they depend on the history of the sets. These are tie-breaking by lowest index, the stale-source path, and the difference between level and edge sources on clearing. They also include the nested order of end-of-interrupt and the asymmetric request rules, where a delivery can raise the request above an in-service source while an acknowledge cannot.

// File: rtl/cpu_iack_pkg.sv
package cpu_iack_pkg;

   // one operation is taken per cycle, in this precedence order
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_ACK  = 2'd1,
      OP_EOI  = 2'd2,
      OP_DLV  = 2'd3
   } iack_op_e;

   function automatic iack_op_e pick_op(input logic ack, input logic eoi, input logic dlv);
      if (ack)      return OP_ACK;
      else if (eoi) return OP_EOI;
      else if (dlv) return OP_DLV;
      else          return OP_NONE;
   endfunction

endpackage

// File: rtl/cpu_iack_prio_scan.sv
// Picks the highest-priority member of a set; ties go to the lowest index.
// SPLIT=1 scans two halves in parallel and merges them (shallower logic).
module cpu_iack_prio_scan #(
   parameter int NUM    = 8,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 3,
   parameter bit SPLIT  = 1'b0
) (
   input  logic [NUM-1:0]        mask,
   input  logic [NUM*PRIO_W-1:0] prio_flat,
   output logic                  found,
   output logic [IDX_W-1:0]      idx,
   output logic [PRIO_W-1:0]     best
);
   localparam int HALF = NUM / 2;

   if (SPLIT && NUM >= 4) begin : g_split
      logic              lo_f, hi_f;
      logic [IDX_W-1:0]  lo_i, hi_i;
      logic [PRIO_W-1:0] lo_b, hi_b;

      always_comb begin
         lo_f = 1'b0;
         lo_i = '0;
         lo_b = '0;
         for (int i = 0; i < HALF; i++) begin
            if (mask[i] && (!lo_f || prio_flat[i*PRIO_W +: PRIO_W] > lo_b)) begin
               lo_f = 1'b1;
               lo_i = IDX_W'(i);
               lo_b = prio_flat[i*PRIO_W +: PRIO_W];
            end
         end
      end

      always_comb begin
         hi_f = 1'b0;
         hi_i = '0;
         hi_b = '0;
         for (int i = HALF; i < NUM; i++) begin
            if (mask[i] && (!hi_f || prio_flat[i*PRIO_W +: PRIO_W] > hi_b)) begin
               hi_f = 1'b1;
               hi_i = IDX_W'(i);
               hi_b = prio_flat[i*PRIO_W +: PRIO_W];
            end
         end
      end

      // upper half wins only when strictly greater: keeps lowest-index tie rule
      always_comb begin
         if (hi_f && (!lo_f || hi_b > lo_b)) begin
            found = 1'b1;
            idx   = hi_i;
            best  = hi_b;
         end else begin
            found = lo_f;
            idx   = lo_i;
            best  = lo_b;
         end
      end
   end else begin : g_linear
      always_comb begin
         found = 1'b0;
         idx   = '0;
         best  = '0;
         for (int i = 0; i < NUM; i++) begin
            if (mask[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
               found = 1'b1;
               idx   = IDX_W'(i);
               best  = prio_flat[i*PRIO_W +: PRIO_W];
            end
         end
      end
   end

endmodule

// File: rtl/cpu_iack_cfg_regs.sv
// Task priority and spurious vector registers with truncating writes.
module cpu_iack_cfg_regs #(
   parameter int              DATA_W   = 32,
   parameter int              PRIO_W   = 4,
   parameter int              VEC_W    = 8,
   parameter logic [PRIO_W-1:0] TPR_RST = '1,
   parameter logic [VEC_W-1:0]  SPV_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tpr_we,
   input  logic              spv_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [PRIO_W-1:0] tpr_q,
   output logic [VEC_W-1:0]  spv_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpr_q <= TPR_RST;
         spv_q <= SPV_RST;
      end else begin
         if (tpr_we) tpr_q <= wdata[PRIO_W-1:0];
         if (spv_we) spv_q <= wdata[VEC_W-1:0];
      end
   end

   assert_tpr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tpr_we |=> $stable(tpr_q));
   assert_spv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !spv_we |=> $stable(spv_q));

endmodule

// File: rtl/cpu_iack_unit.sv
module cpu_iack_unit
   import cpu_iack_pkg::*;
#(
   parameter int NUM_SRC    = 8,
   parameter int PRIO_W     = 4,
   parameter int VEC_W      = 8,
   parameter int DATA_W     = 32,
   parameter bit SPLIT_SCAN = 1'b1,
   localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dlv_valid,
   input  logic [IDX_W-1:0]          dlv_idx,
   input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
   input  logic [NUM_SRC*VEC_W-1:0]  src_vec,
   input  logic [NUM_SRC-1:0]        src_active,
   input  logic [NUM_SRC-1:0]        src_level,
   input  logic                      tpr_we,
   input  logic                      spv_we,
   input  logic [DATA_W-1:0]         cfg_wdata,
   input  logic                      ack_req,
   input  logic                      eoi_req,
   output logic                      irq,
   output logic                      ack_vld,
   output logic [VEC_W-1:0]          ack_vec,
   output logic [NUM_SRC-1:0]        act_clr,
   output logic [PRIO_W-1:0]         task_prio,
   output logic [VEC_W-1:0]          spur_vec
);

   // elaboration-time parameter checks
   if (NUM_SRC < 2)      begin : g_bad_num  $error("NUM_SRC must be at least 2");   end
   if (PRIO_W < 1)       begin : g_bad_prio $error("PRIO_W must be at least 1");    end
   if (PRIO_W > DATA_W)  begin : g_bad_pw   $error("PRIO_W exceeds DATA_W");        end
   if (VEC_W > DATA_W)   begin : g_bad_vw   $error("VEC_W exceeds DATA_W");         end

   logic [NUM_SRC-1:0] pend_q, isr_q;

   cpu_iack_cfg_regs #(
      .DATA_W (DATA_W),
      .PRIO_W (PRIO_W),
      .VEC_W  (VEC_W),
      .TPR_RST({PRIO_W{1'b1}}),
      .SPV_RST({VEC_W{1'b1}})
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .tpr_we (tpr_we),
      .spv_we (spv_we),
      .wdata  (cfg_wdata),
      .tpr_q  (task_prio),
      .spv_q  (spur_vec)
   );

   // ---- best pending source ------------------------------------------------
   logic              pf;
   logic [IDX_W-1:0]  pi;
   logic [PRIO_W-1:0] pb;

   cpu_iack_prio_scan #(.NUM(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .SPLIT(SPLIT_SCAN))
   u_scan_pend (.mask(pend_q), .prio_flat(src_prio), .found(pf), .idx(pi), .best(pb));

   logic [NUM_SRC-1:0] sel_bit, svc_bit;
   logic [VEC_W-1:0]   sel_vec;
   logic               sel_stale, sel_level;

   always_comb begin
      sel_bit   = pf ? (NUM_SRC'(1) << pi) : '0;
      sel_vec   = src_vec[pi*VEC_W +: VEC_W];
      sel_level = src_level[pi];
      sel_stale = !src_active[pi] || !(pb > task_prio);
      svc_bit   = (pf && !sel_stale) ? sel_bit : '0;
   end

   // ---- best pending after the selected one leaves ---------------------------
   logic              rf;
   logic [IDX_W-1:0]  ri_unused;
   logic [PRIO_W-1:0] rb;

   cpu_iack_prio_scan #(.NUM(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .SPLIT(SPLIT_SCAN))
   u_scan_rem (.mask(pend_q & ~sel_bit), .prio_flat(src_prio), .found(rf), .idx(ri_unused), .best(rb));

   // ---- best in-service source ---------------------------------------------
   logic              sf;
   logic [IDX_W-1:0]  si;
   logic [PRIO_W-1:0] sb_unused;
   logic [NUM_SRC-1:0] eoi_bit;

   cpu_iack_prio_scan #(.NUM(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .SPLIT(SPLIT_SCAN))
   u_scan_isr (.mask(isr_q), .prio_flat(src_prio), .found(sf), .idx(si), .best(sb_unused));

   assign eoi_bit = sf ? (NUM_SRC'(1) << si) : '0;

   // ---- operation select -----------------------------------------------------
   logic              dlv_in_range, dlv_new;
   logic [PRIO_W-1:0] dlv_prio;
   iack_op_e          op;

   if (NUM_SRC == (1 << IDX_W)) begin : g_full_idx
      assign dlv_in_range = 1'b1;
   end else begin : g_part_idx
      assign dlv_in_range = ({1'b0, dlv_idx} < (IDX_W+1)'(NUM_SRC));
   end

   assign dlv_prio = src_prio[dlv_idx*PRIO_W +: PRIO_W];
   assign dlv_new  = dlv_valid && dlv_in_range && !pend_q[dlv_idx];
   assign op       = pick_op(ack_req, eoi_req, dlv_new);

   // ---- in-service set as it will be after this cycle's operation ----------
   logic [NUM_SRC-1:0] isr_after;
   logic               af_unused;
   logic [IDX_W-1:0]   ai_unused;
   logic [PRIO_W-1:0]  ab;

   assign isr_after = (op == OP_ACK) ? (isr_q | svc_bit) : (isr_q & ~eoi_bit);

   cpu_iack_prio_scan #(.NUM(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .SPLIT(SPLIT_SCAN))
   u_scan_after (.mask(isr_after), .prio_flat(src_prio), .found(af_unused), .idx(ai_unused), .best(ab));

   // ---- state update -------------------------------------------------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         isr_q   <= '0;
         irq     <= 1'b0;
         ack_vld <= 1'b0;
         ack_vec <= '0;
         act_clr <= '0;
      end else begin
         ack_vld <= 1'b0;
         act_clr <= '0;
         unique case (op)
            OP_ACK: begin
               pend_q  <= pend_q & ~sel_bit;
               isr_q   <= isr_q | svc_bit;
               ack_vld <= 1'b1;
               ack_vec <= (pf && !sel_stale) ? sel_vec : spur_vec;
               act_clr <= (pf && (sel_stale || !sel_level)) ? sel_bit : '0;
               irq     <= rf && (rb > task_prio) && (rb > ab);
            end
            OP_EOI: begin
               isr_q <= isr_q & ~eoi_bit;
               if (pb > ab) irq <= 1'b1;
            end
            OP_DLV: begin
               pend_q[dlv_idx] <= 1'b1;
               if (dlv_prio > pb) irq <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // ---- assertions -----------------------------------------------------------
   assert_ack_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> ack_vld);
   assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_req |=> !ack_vld);
   assert_empty_spur_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && pend_q == '0) |=> (ack_vec == $past(spur_vec) && act_clr == '0));
   assert_clr_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_clr));
   assert_clr_only_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_req |=> act_clr == '0);
   assert_drain_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && $countones(pend_q) == 1) |=> !irq);
   assert_eoi_shrink_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_req && !ack_req && isr_q != '0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

endmodule

// File: tb/tb_cpu_iack_unit.sv
module tb_cpu_iack_unit;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int PW = 4;
   localparam int VW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dlv_valid = 1'b0;
   logic [2:0]    dlv_idx = '0;
   logic [N*PW-1:0] src_prio;
   logic [N*VW-1:0] src_vec;
   logic [N-1:0]  src_active = '1;
   logic [N-1:0]  src_level  = 8'b0000_0100;   // source 2 level-sensitive
   logic          tpr_we = 1'b0, spv_we = 1'b0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          ack_req = 1'b0, eoi_req = 1'b0;
   logic          irq, ack_vld;
   logic [VW-1:0] ack_vec;
   logic [N-1:0]  act_clr;
   logic [PW-1:0] task_prio;
   logic [VW-1:0] spur_vec;

   // source priorities: s0=3 s1=5 s2=5 s3=7 s4=2 s5=4 s6=1 s7=6 ; vector = 0x40+i
   localparam logic [PW-1:0] PRI [N] = '{4'd3, 4'd5, 4'd5, 4'd7, 4'd2, 4'd4, 4'd1, 4'd6};
   always_comb begin
      for (int i = 0; i < N; i++) begin
         src_prio[i*PW +: PW] = PRI[i];
         src_vec[i*VW +: VW]  = 8'h40 + 8'(i);
      end
   end

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_iack_unit dut (
      .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_idx(dlv_idx),
      .src_prio(src_prio), .src_vec(src_vec), .src_active(src_active), .src_level(src_level),
      .tpr_we(tpr_we), .spv_we(spv_we), .cfg_wdata(cfg_wdata),
      .ack_req(ack_req), .eoi_req(eoi_req),
      .irq(irq), .ack_vld(ack_vld), .ack_vec(ack_vec), .act_clr(act_clr),
      .task_prio(task_prio), .spur_vec(spur_vec)
   );

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard of expected acknowledge results
   logic [VW-1:0] q_vec [$];
   logic [N-1:0]  q_clr [$];
   string         q_tag [$];

   always @(negedge clk) begin
      if (rst_n && ack_vld) begin
         if (q_vec.size() == 0) begin
            check("R6 unexpected ack_vld", 32'(ack_vld), 32'h0);
         end else begin
            automatic logic [VW-1:0] ev = q_vec.pop_front();
            automatic logic [N-1:0]  ec = q_clr.pop_front();
            automatic string         et = q_tag.pop_front();
            check({et, " ack_vec"}, 32'(ack_vec), 32'(ev));
            check({et, " act_clr"}, 32'(act_clr), 32'(ec));
         end
      end else if (rst_n) begin
         if (act_clr != '0) check("R11 act_clr outside ack", 32'(act_clr), 32'h0);
      end
   end

   task automatic deliver(input int idx);
      @(negedge clk);
      dlv_valid = 1'b1;
      dlv_idx   = 3'(idx);
      @(negedge clk);
      dlv_valid = 1'b0;
   endtask

   task automatic ack(input logic [VW-1:0] ev, input logic [N-1:0] ec, input string tag);
      q_vec.push_back(ev);
      q_clr.push_back(ec);
      q_tag.push_back(tag);
      @(negedge clk);
      ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
   endtask

   task automatic eoi();
      @(negedge clk);
      eoi_req = 1'b1;
      @(negedge clk);
      eoi_req = 1'b0;
   endtask

   task automatic wr_tpr(input logic [DW-1:0] d);
      @(negedge clk);
      tpr_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      tpr_we = 1'b0;
   endtask

   task automatic wr_spv(input logic [DW-1:0] d);
      @(negedge clk);
      spv_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      spv_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq", 32'(irq), 0);
      check("R1 ack_vld", 32'(ack_vld), 0);
      check("R1 act_clr", 32'(act_clr), 0);
      check("R1 task_prio", 32'(task_prio), 32'hF);
      check("R1 spur_vec", 32'(spur_vec), 32'hFF);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 empty acknowledge returns reset spurious vector
      ack(8'hFF, '0, "R6 empty");
      // R2 truncating writes
      wr_tpr(32'hDEAD_BEA5);
      check("R2 task_prio low bits", 32'(task_prio), 32'h5);
      check("R2 spur_vec untouched", 32'(spur_vec), 32'hFF);
      wr_spv(32'h1234_5677);
      check("R2 spur_vec low bits", 32'(spur_vec), 32'h77);
      check("R2 task_prio untouched", 32'(task_prio), 32'h5);
      wr_tpr(32'h0);

      // R3/R5/R8/R9/R10 main flow, tpr=0
      deliver(2);
      check("R3 irq on first delivery", 32'(irq), 1);
      deliver(1);
      deliver(0);
      ack(8'h41, 8'b0000_0010, "R5 tie lowest index, R8 edge clear");
      check("R9 irq low, remaining not above in-service", 32'(irq), 0);
      ack(8'h42, 8'b0000_0000, "R8 level source no clear");
      check("R9 irq still low", 32'(irq), 0);
      eoi();
      check("R10 eoi keeps irq low while p5 in service", 32'(irq), 0);
      eoi();
      check("R10 eoi re-raises irq", 32'(irq), 1);
      ack(8'h40, 8'b0000_0001, "R8 source 0");
      check("R9 irq drops on empty pending", 32'(irq), 0);
      eoi();
      check("R10 eoi with nothing pending", 32'(irq), 0);

      // R4 duplicate delivery ignored
      deliver(3);
      deliver(3);
      ack(8'h43, 8'b0000_1000, "R4 first ack");
      ack(8'h77, 8'b0000_0000, "R4 duplicate gone, R6 spurious");
      eoi();

      // R7 stale sources
      wr_tpr(32'h4);
      deliver(4);
      check("R3 delivery ignores task priority", 32'(irq), 1);
      ack(8'h77, 8'b0001_0000, "R7 priority not above tpr");
      check("R9 irq after stale drain", 32'(irq), 0);
      wr_tpr(32'h3);
      src_active[5] = 1'b0;
      deliver(5);
      ack(8'h77, 8'b0010_0000, "R7 inactive source");
      src_active[5] = 1'b1;
      eoi();
      check("R7 stale did not enter in-service", 32'(irq), 0);
      deliver(4);
      deliver(7);
      ack(8'h47, 8'b1000_0000, "R8 valid above tpr");
      check("R9 remaining below tpr", 32'(irq), 0);
      ack(8'h77, 8'b0001_0000, "R7 remaining stale");
      eoi();

      // R3 asymmetric raise rule, tpr=0
      wr_tpr(32'h0);
      deliver(3);
      deliver(5);
      ack(8'h43, 8'b0000_1000, "R8 source 3");
      check("R9 p4 below in-service p7", 32'(irq), 0);
      deliver(6);
      check("R3 lower than best pending no raise", 32'(irq), 0);
      deliver(7);
      check("R3 higher than best pending raises", 32'(irq), 1);
      ack(8'h47, 8'b1000_0000, "R5 highest pending");
      check("R9 after ack of s7", 32'(irq), 0);
      ack(8'h45, 8'b0010_0000, "R5 next pending");
      ack(8'h46, 8'b0100_0000, "R5 last pending");
      repeat (4) eoi();
      check("R10 all in-service closed, nothing pending", 32'(irq), 0);
      ack(8'h77, '0, "R6 final empty");

      repeat (2) @(negedge clk);
      check("R6 all acks answered", 32'(q_vec.size()), 0);
      finish_run();
   end
endmodule